// File: doc/BRIEF.md
# Banked Work-Memory Window Controller

This block sits on a CPU bus and maps a 32 KB CPU window at 0x6000–0xDFFF onto a 512 KB external DRAM. It holds separate read and write bank registers, so a program can read from one bank while it loads another. Writing either bank register also picks the single active direction. Reads and writes are never both routed to DRAM at the same moment.

The same register group also holds a 4 KB BIOS page number for the region at 0xE000, an 8 KB video-memory bank number for pattern address 0, a two-bit nametable mirroring mode, and an optional SRAM enable. The block does not hold the memories. It drives the banked high address lines and select strobes, and outside logic uses them to steer each access. A window read that DRAM does not serve goes to the default memory through a separate select.

Top module: `wmem_window_ctrl`

## Requirements
- R1: A CPU write to 0x4190 loads data bits 3:0 into the read bank at the next clock edge. From that edge, DRAM reading is enabled and DRAM writing is disabled.
- R2: A CPU write to 0x4191 loads data bits 3:0 into the write bank at the next clock edge. From that edge, DRAM writing is enabled and DRAM reading is disabled.
- R3: `dram_rd_en` and `dram_wr_en` are never both 1.
- R4: `dram_addr` is {bank, (cpu_addr − 0x6000) bits 14:0}, which equals offset + bank × 0x8000. The bank is the write bank when `cpu_we` is 1 and the read bank otherwise.
- R5: `dram_sel` is 1 only when cpu_addr is in [0x6000, 0xE000) and one of these holds: (a) a write with writing enabled; (b) a read with reading enabled and SRAM disabled. An address of 0xE000 or above never selects DRAM.
- R6: `dflt_sel` is 1 for a read at 0x6000 or above that is served by neither DRAM nor SRAM.
- R7: A write to 0x418D sets `mirror_mode` to data bits 1:0 at the next edge. The codes are 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R8: A write to 0x4198 sets `vram_bank` to data bits 5:0 at the next edge.
- R9: A write to 0x4180 sets `bios_page` to data bits 2:0 at the next edge.
- R10: The same write to 0x4180 sets the SRAM enable from data bit 7. While it is set, any window access asserts `sram_sel`. Window reads then go to SRAM instead of DRAM, and window writes still reach DRAM when writing is enabled.
- R11: After reset, both banks, the BIOS page, the video bank and the mirroring mode are 0. `dram_rd_en` is 1, `dram_wr_en` is 0 and `sram_en` is 0.
- R12: Reads, and writes to any other address (for example 0x4181 or 0x41FF), leave all register outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| dram_addr | output | 19 | Banked DRAM address |
| dram_sel | output | 1 | Current access goes to DRAM |
| dram_rd_en | output | 1 | DRAM reading enabled |
| dram_wr_en | output | 1 | DRAM writing enabled |
| sram_sel | output | 1 | Current access goes to SRAM |
| sram_en | output | 1 | SRAM enable state |
| dflt_sel | output | 1 | Read falls through to default memory |
| bios_page | output | 3 | 4 KB BIOS page at 0xE000 |
| vram_bank | output | 6 | 8 KB video-memory bank |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
Random traffic mixes register writes, window reads and writes, accesses above 0xE000, and arbitrary addresses.
- Window accesses made after alternating read-bank and write-bank loads show whether each direction takes the right bank, and whether it is enabled only after its own register is written.
- Accesses at exactly 0x6000, 0xDFFF and 0xE000 separate an off-by-one window decode from a correct one.
- Writes to unused addresses in the register region check that decoding uses the full address.
- Reads with SRAM enabled show SRAM taking priority on reads but not on writes.

// File: rtl/wmem_pkg.sv
package wmem_pkg;
   typedef enum logic [1:0] {
      MIR_VERT   = 2'd0,
      MIR_HORZ   = 2'd1,
      MIR_ONE_LO = 2'd2,
      MIR_ONE_HI = 2'd3
   } mirror_e;

   localparam logic [15:0] REG_BIOS   = 16'h4180;
   localparam logic [15:0] REG_MIRROR = 16'h418D;
   localparam logic [15:0] REG_RDBANK = 16'h4190;
   localparam logic [15:0] REG_WRBANK = 16'h4191;
   localparam logic [15:0] REG_VBANK  = 16'h4198;
endpackage

// File: rtl/wmem_regs.sv
module wmem_regs
   import wmem_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 4,
   parameter int VBANK_W   = 6,
   parameter int BIOS_W    = 3,
   parameter bit SRAM_CTRL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               we,
   output logic [BANK_W-1:0]  rd_bank,
   output logic [BANK_W-1:0]  wr_bank,
   output logic               rd_en,
   output logic               wr_en,
   output logic               sram_en,
   output logic [BIOS_W-1:0]  bios_page,
   output logic [VBANK_W-1:0] vram_bank,
   output mirror_e            mirror
);
   localparam int SRAM_BIT = DATA_W - 1;

   initial begin
      if (ADDR_W != 16) $error("wmem_regs: ADDR_W must be 16");
      if (DATA_W < BANK_W || DATA_W < VBANK_W || DATA_W < BIOS_W || DATA_W < 2)
         $error("wmem_regs: DATA_W too narrow for a register field");
   end

   logic hit_bios, hit_mir, hit_rdb, hit_wrb, hit_vb;
   always_comb begin
      hit_bios = we && (addr == REG_BIOS);
      hit_mir  = we && (addr == REG_MIRROR);
      hit_rdb  = we && (addr == REG_RDBANK);
      hit_wrb  = we && (addr == REG_WRBANK);
      hit_vb   = we && (addr == REG_VBANK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_bank   <= '0;
         wr_bank   <= '0;
         rd_en     <= 1'b1;
         wr_en     <= 1'b0;
         bios_page <= '0;
         vram_bank <= '0;
         mirror    <= MIR_VERT;
      end else begin
         if (hit_rdb) begin
            rd_bank <= wdata[BANK_W-1:0];
            rd_en   <= 1'b1;
            wr_en   <= 1'b0;
         end else if (hit_wrb) begin
            wr_bank <= wdata[BANK_W-1:0];
            wr_en   <= 1'b1;
            rd_en   <= 1'b0;
         end
         if (hit_bios) bios_page <= wdata[BIOS_W-1:0];
         if (hit_vb)   vram_bank <= wdata[VBANK_W-1:0];
         if (hit_mir)  mirror    <= mirror_e'(wdata[1:0]);
      end
   end

   generate
      if (SRAM_CTRL) begin : g_sram
         always_ff @(posedge clk) begin
            if (!rst_n)        sram_en <= 1'b0;
            else if (hit_bios) sram_en <= wdata[SRAM_BIT];
         end
      end else begin : g_nosram
         assign sram_en = 1'b0;
      end
   endgenerate

   a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));
   a_r1_read_bank: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we) && $past(addr) == REG_RDBANK)
      |-> (rd_en && !wr_en && rd_bank == $past(wdata[BANK_W-1:0])));
   a_r2_write_bank: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we) && $past(addr) == REG_WRBANK)
      |-> (wr_en && !rd_en && wr_bank == $past(wdata[BANK_W-1:0])));
   a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we) && $past(addr) == REG_MIRROR)
      |-> (mirror == mirror_e'($past(wdata[1:0]))));
   a_r12_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(we)) |-> ($stable(rd_bank) && $stable(wr_bank)
      && $stable(bios_page) && $stable(vram_bank) && $stable(mirror)));
endmodule

// File: rtl/wmem_window.sv
module wmem_window #(
   parameter int                ADDR_W    = 16,
   parameter int                BANK_W    = 4,
   parameter int                WIN_BYTES = 32768,
   parameter logic [15:0]       WIN_BASE  = 16'h6000,
   parameter logic [15:0]       WIN_LIMIT = 16'hE000,
   localparam int               OFF_W     = $clog2(WIN_BYTES),
   localparam int               DRAM_AW   = BANK_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               we,
   input  logic               re,
   input  logic [BANK_W-1:0]  rd_bank,
   input  logic [BANK_W-1:0]  wr_bank,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic               sram_en,
   output logic [DRAM_AW-1:0] dram_addr,
   output logic               dram_sel,
   output logic               sram_sel,
   output logic               dflt_sel
);
   initial begin
      if ((1 << OFF_W) != WIN_BYTES) $error("wmem_window: WIN_BYTES must be a power of two");
      if (int'(WIN_LIMIT) - int'(WIN_BASE) != WIN_BYTES)
         $error("wmem_window: window span must equal WIN_BYTES");
   end

   logic              in_win;
   logic [ADDR_W-1:0] rel;
   logic [BANK_W-1:0] bank;

   always_comb begin
      in_win    = (addr >= WIN_BASE) && (addr < WIN_LIMIT);
      rel       = addr - WIN_BASE;
      bank      = we ? wr_bank : rd_bank;
      dram_addr = {bank, rel[OFF_W-1:0]};
      dram_sel  = in_win && ((we && wr_en) || (re && rd_en && !sram_en));
      sram_sel  = in_win && sram_en && (we || re);
      dflt_sel  = re && (addr >= WIN_BASE) && !dram_sel && !sram_sel;
   end

   a_r5_high_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= WIN_LIMIT) |-> !dram_sel);
   a_r5_low_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < WIN_BASE) |-> !dram_sel);
   a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dram_sel && !we, sram_sel && !we, dflt_sel}));
   a_r5_disabled_read: assert property (@(posedge clk) disable iff (!rst_n)
      (re && !we && !rd_en) |-> !dram_sel);
endmodule

// File: rtl/wmem_window_ctrl.sv
module wmem_window_ctrl
   import wmem_pkg::*;
#(
   parameter int  BANK_W    = 4,
   parameter int  VBANK_W   = 6,
   parameter int  BIOS_W    = 3,
   parameter int  WIN_BYTES = 32768,
   parameter bit  SRAM_CTRL = 1'b1,
   localparam int ADDR_W    = 16,
   localparam int DATA_W    = 8,
   localparam int DRAM_AW   = BANK_W + $clog2(WIN_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               cpu_we,
   input  logic               cpu_re,
   output logic [DRAM_AW-1:0] dram_addr,
   output logic               dram_sel,
   output logic               dram_rd_en,
   output logic               dram_wr_en,
   output logic               sram_sel,
   output logic               sram_en,
   output logic               dflt_sel,
   output logic [BIOS_W-1:0]  bios_page,
   output logic [VBANK_W-1:0] vram_bank,
   output logic [1:0]         mirror_mode
);
   logic [BANK_W-1:0] rd_bank, wr_bank;
   mirror_e           mir;

   wmem_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
      .VBANK_W(VBANK_W), .BIOS_W(BIOS_W), .SRAM_CTRL(SRAM_CTRL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata), .we(cpu_we),
      .rd_bank(rd_bank), .wr_bank(wr_bank), .rd_en(dram_rd_en), .wr_en(dram_wr_en),
      .sram_en(sram_en), .bios_page(bios_page), .vram_bank(vram_bank), .mirror(mir)
   );

   wmem_window #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_BYTES(WIN_BYTES),
      .WIN_BASE(16'h6000), .WIN_LIMIT(16'hE000)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .we(cpu_we), .re(cpu_re),
      .rd_bank(rd_bank), .wr_bank(wr_bank), .rd_en(dram_rd_en), .wr_en(dram_wr_en),
      .sram_en(sram_en), .dram_addr(dram_addr), .dram_sel(dram_sel),
      .sram_sel(sram_sel), .dflt_sel(dflt_sel)
   );

   assign mirror_mode = mir;

   a_r8_vram_bank: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cpu_we) && $past(cpu_addr) == REG_VBANK)
      |-> (vram_bank == $past(cpu_wdata[VBANK_W-1:0])));
   a_r9_bios_page: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cpu_we) && $past(cpu_addr) == REG_BIOS)
      |-> (bios_page == $past(cpu_wdata[BIOS_W-1:0])));
endmodule

// File: tb/wmem_window_ctrl_tb.sv
module wmem_window_ctrl_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] cpu_addr = 0;
   logic [7:0]  cpu_wdata = 0;
   logic        cpu_we = 0, cpu_re = 0;
   logic [18:0] dram_addr;
   logic        dram_sel, dram_rd_en, dram_wr_en, sram_sel, sram_en, dflt_sel;
   logic [2:0]  bios_page;
   logic [5:0]  vram_bank;
   logic [1:0]  mirror_mode;

   int n_tests = 0, n_fail = 0;

   // bench model of register state
   logic [3:0] m_rdb, m_wrb;
   logic       m_rde, m_wre, m_sram;
   logic [2:0] m_bios;
   logic [5:0] m_vb;
   logic [1:0] m_mir;

   always #2 clk = ~clk;

   wmem_window_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .dram_addr(dram_addr), .dram_sel(dram_sel),
      .dram_rd_en(dram_rd_en), .dram_wr_en(dram_wr_en), .sram_sel(sram_sel),
      .sram_en(sram_en), .dflt_sel(dflt_sel), .bios_page(bios_page),
      .vram_bank(vram_bank), .mirror_mode(mirror_mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (addr=%h we=%b re=%b)",
                  req, act, exp, cpu_addr, cpu_we, cpu_re);
      end
   endtask

   task automatic model_reset();
      m_rdb = 0; m_wrb = 0; m_rde = 1; m_wre = 0; m_sram = 0;
      m_bios = 0; m_vb = 0; m_mir = 0;
   endtask

   function automatic logic [18:0] exp_addr(input logic [15:0] a, input logic w);
      logic [15:0] off;
      off = a - 16'h6000;
      return {(w ? m_wrb : m_rdb), off[14:0]};
   endfunction

   function automatic logic in_win(input logic [15:0] a);
      return a >= 16'h6000 && a < 16'hE000;
   endfunction

   // compare all outputs against model for current inputs
   task automatic check_all();
      logic ed, es, ef;
      ed = in_win(cpu_addr) && ((cpu_we && m_wre) || (cpu_re && m_rde && !m_sram));
      es = in_win(cpu_addr) && m_sram && (cpu_we || cpu_re);
      ef = cpu_re && cpu_addr >= 16'h6000 && !ed && !es;
      chk("R1 rd_en", dram_rd_en, m_rde);
      chk("R2 wr_en", dram_wr_en, m_wre);
      chk("R3 exclusive", dram_rd_en & dram_wr_en, 0);
      chk("R4 dram_addr", dram_addr, exp_addr(cpu_addr, cpu_we));
      chk("R5 dram_sel", dram_sel, ed);
      chk("R6 dflt_sel", dflt_sel, ef);
      chk("R7 mirror", mirror_mode, m_mir);
      chk("R8 vram_bank", vram_bank, m_vb);
      chk("R9 bios_page", bios_page, m_bios);
      chk("R10 sram_en", sram_en, m_sram);
      chk("R10 sram_sel", sram_sel, es);
   endtask

   task automatic model_update();
      if (!cpu_we) return;
      case (cpu_addr)
         16'h4190: begin m_rdb = cpu_wdata[3:0]; m_rde = 1; m_wre = 0; end
         16'h4191: begin m_wrb = cpu_wdata[3:0]; m_wre = 1; m_rde = 0; end
         16'h418D: m_mir = cpu_wdata[1:0];
         16'h4198: m_vb = cpu_wdata[5:0];
         16'h4180: begin m_bios = cpu_wdata[2:0]; m_sram = cpu_wdata[7]; end
         default: ;
      endcase
   endtask

   // drive at negedge, check just before the rising edge, then update model
   task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w, input logic r);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_we = w; cpu_re = r;
      #1;
      check_all();
      @(posedge clk);
      model_update();
   endtask

   function automatic logic [15:0] pick_addr(input int unsigned k);
      logic [15:0] regs [7];
      regs = '{16'h4180, 16'h418D, 16'h4190, 16'h4191, 16'h4198, 16'h4181, 16'h41FF};
      case (k % 4)
         0: return regs[$urandom % 7];
         1: return 16'h6000 + 16'($urandom % 32768);
         2: return 16'hE000 + 16'($urandom % 8192);
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin : watchdog
      #400000;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1F2E3D4C);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R11: reset state
      #1;
      chk("R11 rd_en", dram_rd_en, 1);
      chk("R11 wr_en", dram_wr_en, 0);
      chk("R11 sram_en", sram_en, 0);
      chk("R11 bios/vram/mir", {bios_page, vram_bank, mirror_mode}, 0);
      // directed: window edges with reset banks
      cyc(16'h6000, 0, 0, 1);
      cyc(16'hDFFF, 0, 0, 1);
      cyc(16'hE000, 0, 0, 1);   // R5: never DRAM at 0xE000
      cyc(16'h4191, 8'hF9, 1, 0); // R2
      cyc(16'h6123, 8'h55, 1, 0); // R4 write uses wr bank
      cyc(16'h7000, 0, 0, 1);     // R6: read disabled -> default
      cyc(16'h4190, 8'hA3, 1, 0); // R1
      cyc(16'hDFFF, 0, 0, 1);
      cyc(16'h4181, 8'hFF, 1, 0); // R12 ignored address
      cyc(16'h41FF, 8'hFF, 1, 0);
      cyc(16'h418D, 8'h03, 0, 1); // R12 read of register does nothing
      cyc(16'h418D, 8'hFE, 1, 0); // R7
      cyc(16'h4198, 8'hFF, 1, 0); // R8
      cyc(16'h4180, 8'h85, 1, 0); // R9, R10
      cyc(16'h8000, 0, 0, 1);     // R10 SRAM read priority
      cyc(16'h8000, 8'h11, 1, 0);
      cyc(16'h4180, 8'h02, 1, 0);
      for (int i = 0; i < 4000; i++) begin
         int unsigned op;
         op = $urandom % 3;
         cyc(pick_addr($urandom), 8'($urandom), op == 1, op == 2);
      end
      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule